// File: doc/BRIEF.md
# Toggle-Handshake Error Interrupt Controller

This block keeps track of global error conditions with two 32-bit registers that are compared against each other. The hardware-owned error register flips a bit when a fresh error is reported. The software-owned acknowledge register is written to flip the same bit back into agreement. A bit counts as pending for as long as the two registers disagree. An error that is already pending is never flipped a second time, so software never loses an unacknowledged report.

Besides error raising, the block turns event-queue notifications and command-sync completions into interrupt pulses. It also accepts page-request notifications and ignores them. Each interrupt output is edge-style: one clock cycle high for each accepted request. Software reads both registers through read ports, writes the acknowledge register through a write port, and gates two of the lines with enable inputs.

Top module: `fault_toggle_irq`

## Requirements
- R1: After synchronous reset, both registers read zero (nothing pending), the illegal-acknowledge flag is low and all pulse outputs are low.
- R2: Bit i is pending when bit i of `err_q` differs from bit i of `ack_q`. A raise request with mask M flips in `err_q`, at the next clock edge, exactly the bits of M that are not pending.
- R3: A raise request whose masked bits are all already pending leaves `err_q` unchanged and produces no `fault_pulse`.
- R4: `fault_pulse` goes high in the cycle after a raise request that flipped at least one bit, and only if `fault_irq_en` was high in the request cycle. It stays high for exactly one cycle per request.
- R5: `evq_pulse` goes high for one cycle after a cycle in which `evq_req` and `evq_en` are both high, and at no other time.
- R6: `sync_pulse` goes high for one cycle after every cycle with `sync_req` high, whatever the enables are.
- R7: An acknowledge write stores `ack_wdata` into `ack_q` unchanged at the next edge, including bits that were not pending.
- R8: An acknowledge write that flips any bit that was not pending sets `illegal_ack`, which stays high until reset. Acknowledge writes never cause `fault_pulse`.
- R9: `pri_req` has no effect: it produces no pulse and does not change either register.
- R10: When a raise request and an acknowledge write happen in the same cycle, the pending bits are taken from the acknowledge value before the write, and both registers update at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_valid | input | 1 | Error-raise request strobe |
| raise_mask | input | W | Error bits to raise |
| evq_req | input | 1 | Event-queue notification |
| evq_en | input | 1 | Event-queue interrupt enable |
| sync_req | input | 1 | Command-sync completion notification |
| pri_req | input | 1 | Page-request notification (ignored) |
| fault_irq_en | input | 1 | Global-error interrupt enable |
| ack_we | input | 1 | Acknowledge register write strobe |
| ack_wdata | input | W | Acknowledge register write value |
| err_q | output | W | Error register read value |
| ack_q | output | W | Acknowledge register read value |
| illegal_ack | output | 1 | Sticky flag: an acknowledge write flipped a non-pending bit |
| fault_pulse | output | 1 | Global-error interrupt pulse |
| evq_pulse | output | 1 | Event-queue interrupt pulse |
| sync_pulse | output | 1 | Command-sync interrupt pulse |

## Verification
The assertions check every cycle that the error register moves only by the non-pending part of a raise mask and that the acknowledge register only ever takes the written value. They also check the gating of each pulse, that the illegal-acknowledge flag stays set, and that page requests leave the state alone. Only the bench scenarios can show the sequences behind these rules. Those are a bit that becomes raisable again once it is acknowledged, a repeated raise of pending bits that stays silent, and a same-cycle raise and acknowledge resolved against the old acknowledge value. The bench checks each of them against its own register model.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;

    // Interrupt lines that produce pulses; the order fixes the vector index.
    typedef enum logic [1:0] {
        LINE_FAULT = 2'd0,
        LINE_EVQ   = 2'd1,
        LINE_SYNC  = 2'd2
    } irq_line_e;

    localparam int NUM_LINES = 3;
    localparam int ERR_W_DEF = 32;

    // Per-line request and gate, carried as one record.
    typedef struct packed {
        logic req;
        logic en;
    } line_ctl_t;

endpackage

// File: rtl/fault_toggle_regs.sv
module fault_toggle_regs #(
    parameter int W = fault_irq_pkg::ERR_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         raise_valid,
    input  logic [W-1:0] raise_mask,
    input  logic         ack_we,
    input  logic [W-1:0] ack_wdata,
    output logic [W-1:0] err_q,
    output logic [W-1:0] ack_q,
    output logic         fresh_any,
    output logic         bad_toggle
);
    logic [W-1:0] pending;
    logic [W-1:0] fresh;

    // Pending is always taken from the registered (pre-write) values.
    always_comb begin
        pending    = err_q ^ ack_q;
        fresh      = raise_valid ? (raise_mask & ~pending) : '0;
        fresh_any  = |fresh;
        bad_toggle = ack_we && (|((ack_q ^ ack_wdata) & ~pending));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
            ack_q <= '0;
        end else begin
            err_q <= err_q ^ fresh;
            if (ack_we) begin
                ack_q <= ack_wdata;
            end
        end
    end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= q | set;
        end
    end
endmodule

// File: rtl/irq_pulser.sv
module irq_pulser #(
    parameter int N = fault_irq_pkg::NUM_LINES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  fault_irq_pkg::line_ctl_t [N-1:0] ctl,
    output logic [N-1:0]                   pulse
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pulse[i] <= 1'b0;
            end else begin
                pulse[i] <= ctl[i].req & ctl[i].en;
            end
        end
    end
endmodule

// File: rtl/fault_toggle_irq.sv
module fault_toggle_irq #(
    parameter int W = fault_irq_pkg::ERR_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         raise_valid,
    input  logic [W-1:0] raise_mask,
    input  logic         evq_req,
    input  logic         evq_en,
    input  logic         sync_req,
    input  logic         pri_req,
    input  logic         fault_irq_en,
    input  logic         ack_we,
    input  logic [W-1:0] ack_wdata,
    output logic [W-1:0] err_q,
    output logic [W-1:0] ack_q,
    output logic         illegal_ack,
    output logic         fault_pulse,
    output logic         evq_pulse,
    output logic         sync_pulse
);
    import fault_irq_pkg::*;

    logic                      fresh_any;
    logic                      bad_toggle;
    line_ctl_t [NUM_LINES-1:0] ctl;
    logic [NUM_LINES-1:0]      pulses;
    logic                      unused_pri;

    // Page requests are accepted and dropped.
    assign unused_pri = pri_req;

    fault_toggle_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .raise_valid (raise_valid),
        .raise_mask  (raise_mask),
        .ack_we      (ack_we),
        .ack_wdata   (ack_wdata),
        .err_q       (err_q),
        .ack_q       (ack_q),
        .fresh_any   (fresh_any),
        .bad_toggle  (bad_toggle)
    );

    sticky_flag u_illegal (
        .clk (clk),
        .rst (rst),
        .set (bad_toggle),
        .q   (illegal_ack)
    );

    always_comb begin
        ctl[LINE_FAULT] = '{req: fresh_any, en: fault_irq_en};
        ctl[LINE_EVQ]   = '{req: evq_req,   en: evq_en};
        ctl[LINE_SYNC]  = '{req: sync_req,  en: 1'b1};
    end

    irq_pulser #(.N(NUM_LINES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .pulse (pulses)
    );

    assign fault_pulse = pulses[LINE_FAULT];
    assign evq_pulse   = pulses[LINE_EVQ];
    assign sync_pulse  = pulses[LINE_SYNC];
endmodule

// File: rtl/fault_toggle_irq_chk.sv
module fault_toggle_irq_chk #(
    parameter int W = fault_irq_pkg::ERR_W_DEF
) (
    input logic         clk,
    input logic         rst,
    input logic         raise_valid,
    input logic [W-1:0] raise_mask,
    input logic         evq_req,
    input logic         evq_en,
    input logic         sync_req,
    input logic         pri_req,
    input logic         fault_irq_en,
    input logic         ack_we,
    input logic [W-1:0] ack_wdata,
    input logic [W-1:0] err_q,
    input logic [W-1:0] ack_q,
    input logic         illegal_ack,
    input logic         fault_pulse,
    input logic         evq_pulse,
    input logic         sync_pulse
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (err_q == '0 && ack_q == '0 && !illegal_ack && !fault_pulse && !evq_pulse && !sync_pulse));

    // R2 and R10: the update uses the acknowledge value from before the write.
    assert_raise_update_R2: assert property (@(posedge clk) disable iff (rst)
        raise_valid |=> err_q == ($past(err_q) ^ ($past(raise_mask) & ~($past(err_q) ^ $past(ack_q)))));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !raise_valid |=> $stable(err_q));

    assert_fault_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && !fault_irq_en) |=> !fault_pulse);

    assert_fault_cause_R4: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> (err_q != $past(err_q)));

    assert_evq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (evq_pulse == ($past(evq_req) && $past(evq_en))));

    assert_sync_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sync_pulse == $past(sync_req)));

    assert_ack_store_R7: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> ack_q == $past(ack_wdata));

    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ack_we |=> $stable(ack_q));

    assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_ack |=> illegal_ack);

    assert_no_fault_from_ack_R8: assert property (@(posedge clk) disable iff (rst)
        !raise_valid |=> !fault_pulse);

    assert_pri_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (pri_req && !raise_valid && !ack_we && !evq_req && !sync_req)
            |=> ($stable(err_q) && $stable(ack_q) && !fault_pulse && !evq_pulse && !sync_pulse));

    assert_same_cycle_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && ack_we) |=> (ack_q == $past(ack_wdata)));
endmodule

bind fault_toggle_irq fault_toggle_irq_chk #(.W(W)) u_chk (.*);

// File: tb/fault_toggle_irq_tb.sv
module fault_toggle_irq_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         raise_valid = 1'b0;
    logic [W-1:0] raise_mask = '0;
    logic         evq_req = 1'b0;
    logic         evq_en = 1'b0;
    logic         sync_req = 1'b0;
    logic         pri_req = 1'b0;
    logic         fault_irq_en = 1'b0;
    logic         ack_we = 1'b0;
    logic [W-1:0] ack_wdata = '0;
    logic [W-1:0] err_q, ack_q;
    logic         illegal_ack, fault_pulse, evq_pulse, sync_pulse;

    int checks = 0;
    int errors = 0;

    // Bench-side register model.
    logic [W-1:0] m_err = '0;
    logic [W-1:0] m_ack = '0;
    logic         m_ill = 1'b0;

    always #10 clk = ~clk;

    fault_toggle_irq #(.W(W)) u_dut (.*);

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        raise_valid = 1'b0; raise_mask = '0; evq_req = 1'b0;
        sync_req = 1'b0; pri_req = 1'b0; ack_we = 1'b0; ack_wdata = '0;
    endtask

    // Issue one cycle of raise and/or ack; update model; return expected fault pulse.
    task automatic cycle_op(input logic rv, input logic [W-1:0] m,
                            input logic aw, input logic [W-1:0] ad, output logic exp_pulse);
        logic [W-1:0] fresh;
        fresh = rv ? (m & ~(m_err ^ m_ack)) : '0;
        if (aw && ((m_ack ^ ad) & ~(m_err ^ m_ack)) != '0) m_ill = 1'b1;
        exp_pulse = (fresh != '0) && fault_irq_en;
        m_err = m_err ^ fresh;
        if (aw) m_ack = ad;
        raise_valid = rv; raise_mask = m; ack_we = aw; ack_wdata = ad;
        step();
        clear_inputs();
    endtask

    task automatic t_reset();
        chk("R1 err_q", err_q, '0);
        chk("R1 ack_q", ack_q, '0);
        chk("R1 illegal_ack", W'(illegal_ack), '0);
        chk("R1 pulses", W'({fault_pulse, evq_pulse, sync_pulse}), '0);
    endtask

    task automatic t_raise_basic();
        logic ep;
        fault_irq_en = 1'b1;
        cycle_op(1'b1, 32'h5, 1'b0, '0, ep);
        chk("R2 err after raise", err_q, m_err);
        chk("R4 fault pulse", W'(fault_pulse), W'(ep));
        step();
        chk("R4 single pulse", W'(fault_pulse), '0);
    endtask

    task automatic t_raise_pending();
        logic ep;
        cycle_op(1'b1, 32'h7, 1'b0, '0, ep);
        chk("R2 only non-pending flipped", err_q, 32'h7);
        chk("R2 pulse on partial new", W'(fault_pulse), W'(ep));
        cycle_op(1'b1, 32'h5, 1'b0, '0, ep);
        chk("R3 err unchanged", err_q, 32'h7);
        chk("R3 no pulse", W'(fault_pulse), '0);
    endtask

    task automatic t_ack_then_reraise();
        logic ep;
        cycle_op(1'b0, '0, 1'b1, 32'h5, ep);
        chk("R7 ack stored", ack_q, 32'h5);
        chk("R8 legal ack no flag", W'(illegal_ack), '0);
        cycle_op(1'b1, 32'h1, 1'b0, '0, ep);
        chk("R2 acked bit raisable again", err_q, 32'h6);
        chk("R4 pulse on reraise", W'(fault_pulse), 32'h1);
    endtask

    task automatic t_enable_off();
        logic ep;
        fault_irq_en = 1'b0;
        cycle_op(1'b1, 32'h100, 1'b0, '0, ep);
        chk("R4 err updates when disabled", err_q, m_err);
        chk("R4 no pulse when disabled", W'(fault_pulse), '0);
        fault_irq_en = 1'b1;
    endtask

    task automatic t_illegal_ack();
        logic ep;
        logic [W-1:0] v;
        v = m_ack ^ 32'h800;
        cycle_op(1'b0, '0, 1'b1, v, ep);
        chk("R7 non-pending write stored", ack_q, v);
        chk("R8 illegal flag set", W'(illegal_ack), 32'h1);
        chk("R8 no fault pulse from ack", W'(fault_pulse), '0);
        step();
        chk("R8 flag sticky", W'(illegal_ack), 32'h1);
        cycle_op(1'b1, 32'h800, 1'b0, '0, ep);
        chk("R3 pending via ack not reflipped", err_q, m_err);
        chk("R3 no pulse for pending", W'(fault_pulse), '0);
    endtask

    task automatic t_evq();
        evq_en = 1'b1; evq_req = 1'b1; step(); evq_req = 1'b0;
        chk("R5 evq pulse enabled", W'(evq_pulse), 32'h1);
        step();
        chk("R5 evq single pulse", W'(evq_pulse), '0);
        evq_en = 1'b0; evq_req = 1'b1; step(); evq_req = 1'b0;
        chk("R5 evq gated off", W'(evq_pulse), '0);
    endtask

    task automatic t_sync();
        evq_en = 1'b0; fault_irq_en = 1'b0;
        sync_req = 1'b1; step(); sync_req = 1'b0;
        chk("R6 sync pulse ungated", W'(sync_pulse), 32'h1);
        step();
        chk("R6 sync single pulse", W'(sync_pulse), '0);
        fault_irq_en = 1'b1;
    endtask

    task automatic t_pri();
        pri_req = 1'b1; step(); pri_req = 1'b0;
        chk("R9 no pulse", W'({fault_pulse, evq_pulse, sync_pulse}), '0);
        chk("R9 err unchanged", err_q, m_err);
        chk("R9 ack unchanged", ack_q, m_ack);
    endtask

    task automatic t_same_cycle();
        logic ep;
        logic [W-1:0] wr;
        // Bit 1 is pending; the write clears it while a raise targets bits 1 and 12.
        // Pre-write pending holds bit 1, so only bit 12 flips.
        wr = m_ack ^ 32'h2;
        cycle_op(1'b1, 32'h1002, 1'b1, wr, ep);
        chk("R10 err uses pre-write ack", err_q, m_err);
        chk("R10 ack written same edge", ack_q, wr);
        chk("R10 pulse", W'(fault_pulse), W'(ep));
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raise_basic();
        t_raise_pending();
        t_ack_then_reraise();
        t_enable_off();
        t_illegal_ack();
        t_evq();
        t_sync();
        t_pri();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule